// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a processor-side request port and a slower main-memory port and keeps temporary copies of memory words. Each line holds one word and is addressed by word. The low-order index bits of the word address pick exactly one line. The remaining upper bits are kept as a tag beside the data in a single tag-plus-data array, and one comparator checks that tag against the request.

A read that hits is answered from the array without touching memory. A read that misses fetches the word from memory, installs it and returns it. Every write is forwarded to memory. A write that misses claims its line directly with the new word, and no memory read is made, because a line is only one word wide. Two addresses that share index bits compete for the same line and evict each other.

The processor port uses a valid/ready handshake and accepts one request at a time. The memory port has separate read and write request lines, and each is held until memory acknowledges it. Single-cycle hit and miss pulses allow references to be counted.

Top module: `dm_wt_cache`

## Requirements
- R1: Reset clears every line's valid bit and sets `cpu_req_ready` to 1. It also clears `cpu_rsp_valid`, `mem_rd_req` and `mem_wr_req`. The first access to any address after a reset is a miss.
- R2: The line index is the low IDX_W bits of the word address, and the tag is the remaining upper bits. A hit requires a set valid bit and an equal tag. With 1024 lines, word addresses 1024 and 2048 both use line 0, and each evicts the other.
- R3: A read hit raises `cpu_rsp_valid` with the cached word on the second rising edge after acceptance, together with `hit_pulse`. It makes no memory read.
- R4: A read miss raises `miss_pulse` and `mem_rd_req` on the second edge after acceptance, with `mem_addr` equal to the word address. Both stay stable until `mem_ack`. On the edge that samples `mem_ack`, the returned word appears on `cpu_rsp_rdata` with `cpu_rsp_valid` high, and the line is installed.
- R5: Every accepted write raises `mem_wr_req` on the second edge after acceptance, carrying its address and data. These are held until `mem_ack`. Completion raises `cpu_rsp_valid`.
- R6: A write hit replaces the cached word, so a later read hit returns the new value.
- R7: A write miss installs the new tag and word without any memory read, so a following read of that address hits.
- R8: `cpu_req_ready` is low from the edge after acceptance until the request completes. It is low whenever a memory request is pending, and it is high in any cycle with `cpu_rsp_valid`.
- R9: Each accepted request produces exactly one single-cycle pulse, on `hit_pulse` or `miss_pulse` and never both, on the second edge after acceptance.
- R10: `mem_rd_req` and `mem_wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Request completed (read data valid on reads) |
| cpu_rsp_rdata | output | DATA_W | Read data |
| hit_pulse | output | 1 | One-cycle hit indication |
| miss_pulse | output | 1 | One-cycle miss indication |
| mem_rd_req | output | 1 | Memory read request, held until ack |
| mem_wr_req | output | 1 | Memory write request, held until ack |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with ack |

## Verification
The properties assume that memory raises `mem_ack` for exactly one cycle, and only while a read or write request is pending. They also assume that the processor side changes its request only at a clock edge. The bench memory model keeps to this. It counts a fixed latency from the start of a request, pulses the acknowledge once, and returns data in the same cycle. The processor stimulus is driven on falling edges and drops `cpu_req_valid` right after acceptance.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_MEM_RD = 2'd2,
    ST_MEM_WR = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_line_ram.sv
// Tag-plus-data store: one write port, one synchronous read port (block RAM style).
module cache_line_ram #(
  parameter int IDX_W  = 10,
  parameter int WORD_W = 38
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= store[rd_idx];
  end
endmodule

// File: rtl/cache_valid_bits.sv
// Per-line valid flags, all cleared by reset.
module cache_valid_bits #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst)         flags <= '0;
    else if (set_en) flags[set_idx] <= 1'b1;
  end

  assign rd_valid = flags[rd_idx];
endmodule

// File: rtl/cache_tag_cmp.sv
// Single comparator deciding hit or miss.
module cache_tag_cmp #(
  parameter int TAG_W = 6
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);
  always_comb hit = line_valid && (stored_tag == req_tag);
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              hit_pulse,
  output logic              miss_pulse,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import cache_pkg::*;

  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = TAG_W + DATA_W;

  cache_state_e      state;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;

  logic              accept;
  logic [LINE_W-1:0] line_word;
  logic              line_valid;
  logic              lookup_hit;
  logic              fill_en;
  logic [LINE_W-1:0] fill_word;

  wire [IDX_W-1:0] req_idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] req_tag = req_addr[ADDR_W-1:IDX_W];

  assign accept = (state == ST_IDLE) && cpu_req_valid && cpu_req_ready;

  // Array is written either by a write in lookup or by a memory fill.
  always_comb begin
    fill_en   = ((state == ST_LOOKUP) && req_we) || ((state == ST_MEM_RD) && mem_ack);
    fill_word = {req_tag, (req_we ? req_wdata : mem_rdata)};
  end

  cache_line_ram #(.IDX_W(IDX_W), .WORD_W(LINE_W)) u_ram (
    .clk     (clk),
    .rd_en   (accept),
    .rd_idx  (cpu_req_addr[IDX_W-1:0]),
    .rd_word (line_word),
    .wr_en   (fill_en),
    .wr_idx  (req_idx),
    .wr_word (fill_word)
  );

  cache_valid_bits #(.IDX_W(IDX_W)) u_valid (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (req_idx),
    .rd_valid (line_valid),
    .set_en   (fill_en),
    .set_idx  (req_idx)
  );

  cache_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .line_valid (line_valid),
    .stored_tag (line_word[LINE_W-1:DATA_W]),
    .req_tag    (req_tag),
    .hit        (lookup_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      req_we        <= 1'b0;
      req_addr      <= '0;
      req_wdata     <= '0;
      cpu_req_ready <= 1'b1;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      hit_pulse     <= 1'b0;
      miss_pulse    <= 1'b0;
      mem_rd_req    <= 1'b0;
      mem_wr_req    <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      hit_pulse     <= 1'b0;
      miss_pulse    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_we        <= cpu_req_we;
            req_addr      <= cpu_req_addr;
            req_wdata     <= cpu_req_wdata;
            cpu_req_ready <= 1'b0;
            state         <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          hit_pulse  <= lookup_hit;
          miss_pulse <= !lookup_hit;
          if (req_we) begin
            mem_wr_req <= 1'b1;
            mem_addr   <= req_addr;
            mem_wdata  <= req_wdata;
            state      <= ST_MEM_WR;
          end else if (lookup_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= line_word[DATA_W-1:0];
            cpu_req_ready <= 1'b1;
            state         <= ST_IDLE;
          end else begin
            mem_rd_req <= 1'b1;
            mem_addr   <= req_addr;
            state      <= ST_MEM_RD;
          end
        end
        ST_MEM_RD: begin
          if (mem_ack) begin
            mem_rd_req    <= 1'b0;
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= mem_rdata;
            cpu_req_ready <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        ST_MEM_WR: begin
          if (mem_ack) begin
            mem_wr_req    <= 1'b0;
            cpu_rsp_valid <= 1'b1;
            cpu_req_ready <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_wt_cache_checker.sv
module dm_wt_cache_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_req_we,
  input logic [ADDR_W-1:0] cpu_req_addr,
  input logic [DATA_W-1:0] cpu_req_wdata,
  input logic              cpu_rsp_valid,
  input logic              hit_pulse,
  input logic              miss_pulse,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  localparam int LINES = 1 << IDX_W;

  assert_hit_miss_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(hit_pulse && miss_pulse));

  assert_pulse_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready ##1 (hit_pulse || miss_pulse));

  assert_no_dual_mem_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> !cpu_req_ready);

  assert_rsp_ready_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> cpu_req_ready);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && cpu_req_we) |=> ##1
      (mem_wr_req && mem_addr == $past(cpu_req_addr, 2) && mem_wdata == $past(cpu_req_wdata, 2)));

  assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    hit_pulse |-> !mem_rd_req);

  assert_miss_goes_out_R4: assert property (@(posedge clk) disable iff (rst)
    miss_pulse |-> (mem_rd_req || mem_wr_req));

  initial begin
    assert_lines_R2: assert (LINES >= 2);
  end
endmodule

bind dm_wt_cache dm_wt_cache_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
  .cpu_rsp_valid(cpu_rsp_valid), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
  .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/dm_wt_cache_tb.sv
`timescale 1ns/1ps
module dm_wt_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 10;
  localparam int LINES  = 1 << IDX_W;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, hit_pulse, miss_pulse;
  logic [DATA_W-1:0] cpu_rsp_rdata, mem_wdata;
  logic mem_rd_req, mem_wr_req;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  dm_wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- main-memory model ----------------
  logic [DATA_W-1:0] mem_store [int];
  int mem_reads = 0, mem_writes = 0, lat_cnt = 0;

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      lat_cnt = 0;
    end else if (mem_rd_req || mem_wr_req) begin
      if (lat_cnt == MEM_LAT - 1) begin
        mem_ack <= 1'b1;
        if (mem_rd_req) begin
          mem_reads++;
          mem_rdata <= mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)]
                                                        : init_word(int'(mem_addr));
        end else begin
          mem_writes++;
          mem_store[int'(mem_addr)] = mem_wdata;
        end
      end else lat_cnt++;
    end
  end

  // ---------------- reference model ----------------
  bit               ref_valid [int];
  int               ref_tag   [int];
  logic [DATA_W-1:0] ref_data [int];
  logic [DATA_W-1:0] ref_mem  [int];

  function automatic logic [DATA_W-1:0] ref_mem_word(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  // Every-clock comparison of port relations the model fixes.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(!(hit_pulse && miss_pulse), "R9 pulses exclusive", {hit_pulse, miss_pulse}, 0);
      check(!(mem_rd_req && mem_wr_req), "R10 one memory command", {mem_rd_req, mem_wr_req}, 0);
      if (cpu_rsp_valid) check(cpu_req_ready, "R8 ready with response", cpu_req_ready, 1);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_valid.delete();
    check(cpu_req_ready == 1'b1, "R1 ready after reset", cpu_req_ready, 1);
    check(!cpu_rsp_valid && !mem_rd_req && !mem_wr_req, "R1 quiet after reset",
          {cpu_rsp_valid, mem_rd_req, mem_wr_req}, 0);
  endtask

  task automatic access(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                        input string tag_s);
    int idx = addr % LINES;
    int tg  = addr / LINES;
    bit exp_hit = ref_valid.exists(idx) && ref_tag[idx] == tg;
    int rd0 = mem_reads;
    int wr0 = mem_writes;
    int n = 0;
    logic [DATA_W-1:0] exp_rd;
    exp_rd = exp_hit ? ref_data[idx] : ref_mem_word(addr);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we;
    cpu_req_addr = addr[ADDR_W-1:0]; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check(!cpu_req_ready, {"R8 busy after accept ", tag_s}, cpu_req_ready, 0);
    @(negedge clk);
    check(hit_pulse == exp_hit && miss_pulse == !exp_hit, {"R9/R2 hit decision ", tag_s},
          {hit_pulse, miss_pulse}, {exp_hit, !exp_hit});
    if (we) begin
      check(mem_wr_req && mem_addr == addr[ADDR_W-1:0] && mem_wdata == wd,
            {"R5 write through ", tag_s}, mem_wdata, wd);
    end else if (!exp_hit) begin
      check(mem_rd_req && mem_addr == addr[ADDR_W-1:0] && !cpu_rsp_valid,
            {"R4 fetch issued ", tag_s}, mem_addr, addr);
    end
    while (!cpu_rsp_valid && n < 40) begin @(negedge clk); n++; end
    check(cpu_rsp_valid && cpu_req_ready, {"R8 completion ", tag_s},
          {cpu_rsp_valid, cpu_req_ready}, 3);
    if (!we) begin
      if (exp_hit) check(cpu_rsp_rdata == exp_rd, {"R3 hit data ", tag_s}, cpu_rsp_rdata, exp_rd);
      else         check(cpu_rsp_rdata == exp_rd, {"R4 fill data ", tag_s}, cpu_rsp_rdata, exp_rd);
      check(mem_reads - rd0 == (exp_hit ? 0 : 1), {"R3 memory reads ", tag_s}, mem_reads - rd0,
            exp_hit ? 0 : 1);
    end else begin
      check(mem_reads == rd0, {"R7 no fetch on write ", tag_s}, mem_reads - rd0, 0);
      check(mem_writes - wr0 == 1, {"R5 one memory write ", tag_s}, mem_writes - wr0, 1);
    end
    if (we || !exp_hit) begin
      ref_valid[idx] = 1'b1;
      ref_tag[idx]   = tg;
      ref_data[idx]  = we ? wd : exp_rd;
    end
    if (we) ref_mem[addr] = wd;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    access(0, 1024, 0, "first read misses R1");
    access(0, 1024, 0, "repeat hit R3");
    access(0, 2048, 0, "conflict evicts R2");
    access(0, 1024, 0, "evicted line misses R2");
    access(0, 37, 0, "read miss R4");
    access(0, 37, 0, "installed line R4");
    access(1, 37, 32'hCAFE0001, "write hit R6");
    access(0, 37, 0, "read after write hit R6");
    access(1, 3000, 32'hBEEF0002, "write miss R7");
    access(0, 3000, 0, "read after write miss R7");
    access(1, 952, 32'h12345678, "write miss evicts R7");
    access(0, 3000, 0, "memory holds written word R5");
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 12; a++) access(0, a, 0, "sweep R3");
    access(1, 5, 32'h0F0F0F0F, "sweep write R6");
    access(0, 5, 0, "sweep read back R6");
    do_reset();
    access(0, 37, 0, "miss after second reset R1");
    access(0, 5, 0, "memory kept across reset R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule